// File: doc/BRIEF.md
# Flash Bank Command Sequence Decoder

This block is the command front end of one bank in a NOR-style flash model. It watches the bus write cycles aimed at the bank and follows the multi-cycle unlock sequences. It decides which mode the bank is in: array read, ID readout, fast-program bypass, embedded program, the sector-erase append window, embedded erase, or erase suspended. It issues one-cycle start, suspend and resume strobes to an external stand-in for the embedded program and erase engines. That stand-in reports completion through a single done input.

While the bank is in ID readout mode, a combinational read port returns the manufacturer code, the three device ID words, the secured-region lock code and the per-sector protection flag. The result depends on the offset presented with the read. A command is honoured only in the modes where it is legal. Anything else either aborts the partial sequence or leaves the state as it was.

Addresses are split in two. The top `$clog2(NUM_SECT)` bits select the sector. The remaining low bits form the in-sector offset. Unlock cycles compare the offset only.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode_o` is 0 (read), all strobes are low, `erase_mask_o` is zero, and `rd_data_o` is zero.
- R2: Mode codes are: 0 read, 1 ID readout, 2 bypass, 3 programming, 4 erase append window, 5 erasing, 6 suspended. The writes AAh@555h, 55h@2AAh and 90h@555h (offsets) move the bank to mode 1. In mode 1, read offset 00h returns `MFR_ID`, and offsets 01h, 0Eh and 0Fh return `DEV_ID1`, `DEV_ID2` and `DEV_ID3`.
- R3: Read offset 03h in mode 1 returns 0081h when `fact_lock_i` is high, 0041h when only `cust_lock_i` is high, and 0001h otherwise.
- R4: Read offset 02h in mode 1 returns 0001h if the sector in the read address is protected in `sect_prot_i`, and 0000h otherwise. Other offsets return 0000h. Outside mode 1, `rd_data_o` is 0000h.
- R5: A write of F0h in mode 0 or mode 1 returns the bank to the mode it entered ID readout from (0 or 6).
- R6: After the two unlock cycles, A0h@555h followed by one data write raises `prog_start_o` for one cycle. This comes with that write's address and data on `prog_addr_o` and `prog_data_o`, and mode 3. `op_done_i` in mode 3 returns the bank to the mode it came from.
- R7: After the two unlock cycles, 20h@555h enters mode 2. In mode 2, a single A0h write followed by a data write programs. F0h is ignored. Only 90h followed by 00h returns the bank to mode 0.
- R8: A lone A0h write outside mode 2, followed by a data write, starts no program and leaves the mode unchanged.
- R9: Unlock, 80h@555h, unlock, then 30h to a sector address enters mode 4 with that sector's bit set in `erase_mask_o`.
- R10: In mode 4, each 30h write adds its sector and restarts a window of `TIMEOUT_CYC` cycles. When the window runs out, `erase_start_o` pulses and the mode becomes 5. Later 30h writes no longer change the mask.
- R11: B0h is accepted only in mode 5. It moves the bank to mode 6 with a one-cycle `suspend_o`. In mode 0, B0h has no effect.
- R12: A 30h write in mode 6 outside any sequence pulses `resume_o` and returns the bank to mode 5. `op_done_i` in mode 5 returns the bank to mode 0 and clears the mask.
- R13: In mode 6, a program to a sector outside the mask is started and returns to mode 6 when done. A program to a masked sector is ignored. ID readout may be entered, and F0h returns the bank to mode 6.
- R14: Any write that does not match the expected next cycle of a sequence aborts that sequence, so a later valid-looking third cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write cycle strobe |
| wr_addr_i | input | ADDR_W | Write address (sector bits on top) |
| wr_data_i | input | 8 | Write data, low byte |
| rd_addr_i | input | ADDR_W | ID readout address |
| rd_data_o | output | 16 | ID readout data |
| sect_prot_i | input | NUM_SECT | Per-sector protection flags |
| fact_lock_i | input | 1 | Secured region locked at factory |
| cust_lock_i | input | 1 | Secured region locked by customer |
| op_done_i | input | 1 | Embedded program or erase finished |
| mode_o | output | 3 | Current bank mode code |
| prog_start_o | output | 1 | Program start strobe |
| prog_addr_o | output | ADDR_W | Address to program |
| prog_data_o | output | 8 | Data to program |
| erase_start_o | output | 1 | Erase start strobe |
| erase_mask_o | output | NUM_SECT | Sectors queued for erase |
| suspend_o | output | 1 | Erase suspend strobe |
| resume_o | output | 1 | Erase resume strobe |

## Verification
Each write is held for one clock and sampled at the next falling edge. At that point every registered result it causes is already visible: mode, strobes, program address and data, and the erase mask. A strobe is high only during that one cycle. ID readout data is combinational from the read address and current mode, so the bench checks it shortly after changing the address. The erase start falls exactly `TIMEOUT_CYC` edges after the last accepted 30h write. The bench therefore counts falling edges from that write, checks that mode 4 still holds one edge before the deadline, and checks the pulse at the deadline.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    MODE_READ      = 3'd0,
    MODE_AUTOSEL   = 3'd1,
    MODE_BYPASS    = 3'd2,
    MODE_PROGRAM   = 3'd3,
    MODE_ERASE_WIN = 3'd4,
    MODE_ERASING   = 3'd5,
    MODE_SUSPENDED = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RESET,
    CMD_AUTOSEL,
    CMD_PROGRAM,
    CMD_BYP_ENTER,
    CMD_BYP_EXIT,
    CMD_ERASE
  } cmd_e;

  localparam logic [7:0] D_UNLOCK1  = 8'hAA;
  localparam logic [7:0] D_UNLOCK2  = 8'h55;
  localparam logic [7:0] D_AUTOSEL  = 8'h90;
  localparam logic [7:0] D_PROG     = 8'hA0;
  localparam logic [7:0] D_BYPASS   = 8'h20;
  localparam logic [7:0] D_ERSETUP  = 8'h80;
  localparam logic [7:0] D_SECT     = 8'h30;
  localparam logic [7:0] D_SUSPEND  = 8'hB0;
  localparam logic [7:0] D_RESET    = 8'hF0;
  localparam logic [7:0] D_BYP_EXIT = 8'h00;

  localparam logic [11:0] A_UNLOCK1 = 12'h555;
  localparam logic [11:0] A_UNLOCK2 = 12'h2AA;

  localparam logic [7:0] OFF_MFR  = 8'h00;
  localparam logic [7:0] OFF_DEV1 = 8'h01;
  localparam logic [7:0] OFF_PROT = 8'h02;
  localparam logic [7:0] OFF_SEC  = 8'h03;
  localparam logic [7:0] OFF_DEV2 = 8'h0E;
  localparam logic [7:0] OFF_DEV3 = 8'h0F;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq import fcd_pkg::*; #(
  parameter int OFF_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bypass_i,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i,
  output cmd_e             cmd_o,
  output logic             idle_o
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PDATA, ST_E1, ST_E2, ST_E3, ST_BX
  } stage_e;

  stage_e stage_q, stage_d;
  logic   at_u1, at_u2;

  assign at_u1  = (wr_off_i == OFF_W'(A_UNLOCK1));
  assign at_u2  = (wr_off_i == OFF_W'(A_UNLOCK2));
  assign idle_o = (stage_q == ST_IDLE);

  always_comb begin
    cmd_o   = CMD_NONE;
    stage_d = stage_q;
    if (!en_i) begin
      stage_d = ST_IDLE;
    end else if (wr_en_i) begin
      stage_d = ST_IDLE; // any mismatch falls back to idle
      if (stage_q != ST_PDATA && stage_q != ST_BX && wr_data_i == D_RESET) begin
        cmd_o = CMD_RESET;
      end else begin
        unique case (stage_q)
          ST_IDLE: begin
            if (bypass_i) begin
              if (wr_data_i == D_PROG)         stage_d = ST_PDATA;
              else if (wr_data_i == D_AUTOSEL) stage_d = ST_BX;
            end else if (wr_data_i == D_UNLOCK1 && at_u1) begin
              stage_d = ST_U1;
            end
          end
          ST_U1: if (wr_data_i == D_UNLOCK2 && at_u2) stage_d = ST_U2;
          ST_U2: begin
            if (at_u1) begin
              unique case (wr_data_i)
                D_AUTOSEL: cmd_o   = CMD_AUTOSEL;
                D_PROG:    stage_d = ST_PDATA;
                D_BYPASS:  cmd_o   = CMD_BYP_ENTER;
                D_ERSETUP: stage_d = ST_E1;
                default:   ;
              endcase
            end
          end
          ST_PDATA: cmd_o = CMD_PROGRAM;
          ST_E1: if (wr_data_i == D_UNLOCK1 && at_u1) stage_d = ST_E2;
          ST_E2: if (wr_data_i == D_UNLOCK2 && at_u2) stage_d = ST_E3;
          ST_E3: if (wr_data_i == D_SECT) cmd_o = CMD_ERASE;
          ST_BX: if (wr_data_i == D_BYP_EXIT) cmd_o = CMD_BYP_EXIT;
          default: stage_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= ST_IDLE;
    else         stage_q <= stage_d;
  end

  // R7: the bypass exit pair is only ever recognised while bypass is active
  a_r7_exit_in_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_BYP_EXIT) |-> bypass_i);

  // R14: the program data cycle is reached only with the sequencer enabled
  a_r14_pdata_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == ST_PDATA) |-> $past(en_i));
endmodule

// File: rtl/fcd_erase_win.sv
module fcd_erase_win #(
  parameter int NUM_SECT    = 8,
  parameter int TIMEOUT_CYC = 16,
  localparam int SECT_W     = $clog2(NUM_SECT),
  localparam int CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic [SECT_W-1:0]   add_sect_i,
  input  logic                run_i,
  output logic                expire_o,
  output logic [NUM_SECT-1:0] mask_o
);
  logic [CNT_W-1:0]    cnt_q;
  logic [NUM_SECT-1:0] mask_q;
  logic [NUM_SECT-1:0] sect_oh;

  always_comb begin
    sect_oh = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (add_sect_i == SECT_W'(i)) sect_oh[i] = 1'b1;
    end
  end

  // an append in the last window cycle wins over expiry
  assign expire_o = run_i && !add_i && (cnt_q == CNT_W'(1));
  assign mask_o   = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (add_i) begin
      cnt_q  <= CNT_W'(TIMEOUT_CYC);
      mask_q <= mask_q | sect_oh;
    end else if (run_i && cnt_q != '0) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  a_r10_expire_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (mask_q != '0));

  a_r9_add_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !clr_i) |=> (($past(sect_oh) & mask_q) != '0));
endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom import fcd_pkg::*; #(
  parameter int          NUM_SECT = 8,
  parameter int          OFF_W    = 13,
  parameter logic [15:0] MFR_ID   = 16'h00C5,
  parameter logic [15:0] DEV_ID1  = 16'h2210,
  parameter logic [15:0] DEV_ID2  = 16'h2211,
  parameter logic [15:0] DEV_ID3  = 16'h2212,
  localparam int         SECT_W   = $clog2(NUM_SECT)
) (
  input  logic [OFF_W-1:0]    off_i,
  input  logic [SECT_W-1:0]   sect_i,
  input  logic [NUM_SECT-1:0] sect_prot_i,
  input  logic                fact_lock_i,
  input  logic                cust_lock_i,
  output logic [15:0]         data_o
);
  logic [7:0] sec_code;

  always_comb begin
    if (fact_lock_i)      sec_code = 8'h81;
    else if (cust_lock_i) sec_code = 8'h41;
    else                  sec_code = 8'h01;
  end

  always_comb begin
    data_o = '0;
    if (off_i == OFF_W'(OFF_MFR))       data_o = MFR_ID;
    else if (off_i == OFF_W'(OFF_DEV1)) data_o = DEV_ID1;
    else if (off_i == OFF_W'(OFF_DEV2)) data_o = DEV_ID2;
    else if (off_i == OFF_W'(OFF_DEV3)) data_o = DEV_ID3;
    else if (off_i == OFF_W'(OFF_PROT)) data_o = {15'd0, sect_prot_i[sect_i]};
    else if (off_i == OFF_W'(OFF_SEC))  data_o = {8'h00, sec_code};
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder import fcd_pkg::*; #(
  parameter int          ADDR_W      = 16,
  parameter int          NUM_SECT    = 8,
  parameter int          TIMEOUT_CYC = 16,
  parameter logic [15:0] MFR_ID      = 16'h00C5,
  parameter logic [15:0] DEV_ID1     = 16'h2210,
  parameter logic [15:0] DEV_ID2     = 16'h2211,
  parameter logic [15:0] DEV_ID3     = 16'h2212
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [15:0]         rd_data_o,
  input  logic [NUM_SECT-1:0] sect_prot_i,
  input  logic                fact_lock_i,
  input  logic                cust_lock_i,
  input  logic                op_done_i,
  output logic [2:0]          mode_o,
  output logic                prog_start_o,
  output logic [ADDR_W-1:0]   prog_addr_o,
  output logic [7:0]          prog_data_o,
  output logic                erase_start_o,
  output logic [NUM_SECT-1:0] erase_mask_o,
  output logic                suspend_o,
  output logic                resume_o
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int OFF_W  = ADDR_W - SECT_W;

  mode_e mode_q, mode_d, ret_q, ret_d;
  cmd_e  cmd;
  logic  seq_idle, seq_en;
  logic  prog_d, susp_d, res_d;
  logic  win_clr, win_add, win_exp;
  logic  prog_q, erase_q, susp_q, res_q;
  logic  [ADDR_W-1:0] prog_addr_q;
  logic  [7:0]        prog_data_q;
  logic  [15:0]       rom_data;
  logic  [SECT_W-1:0] wr_sect;
  logic  [NUM_SECT-1:0] mask;

  assign wr_sect = wr_addr_i[ADDR_W-1 -: SECT_W];
  assign seq_en  = (mode_q == MODE_READ) || (mode_q == MODE_AUTOSEL) ||
                   (mode_q == MODE_BYPASS) || (mode_q == MODE_SUSPENDED);

  fcd_seq #(.OFF_W(OFF_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (seq_en),
    .bypass_i  (mode_q == MODE_BYPASS),
    .wr_en_i   (wr_en_i),
    .wr_off_i  (wr_addr_i[OFF_W-1:0]),
    .wr_data_i (wr_data_i),
    .cmd_o     (cmd),
    .idle_o    (seq_idle)
  );

  fcd_erase_win #(.NUM_SECT(NUM_SECT), .TIMEOUT_CYC(TIMEOUT_CYC)) i_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (win_clr),
    .add_i      (win_add),
    .add_sect_i (wr_sect),
    .run_i      (mode_q == MODE_ERASE_WIN),
    .expire_o   (win_exp),
    .mask_o     (mask)
  );

  fcd_id_rom #(
    .NUM_SECT(NUM_SECT), .OFF_W(OFF_W), .MFR_ID(MFR_ID),
    .DEV_ID1(DEV_ID1), .DEV_ID2(DEV_ID2), .DEV_ID3(DEV_ID3)
  ) i_rom (
    .off_i       (rd_addr_i[OFF_W-1:0]),
    .sect_i      (rd_addr_i[ADDR_W-1 -: SECT_W]),
    .sect_prot_i (sect_prot_i),
    .fact_lock_i (fact_lock_i),
    .cust_lock_i (cust_lock_i),
    .data_o      (rom_data)
  );

  always_comb begin
    mode_d  = mode_q;
    ret_d   = ret_q;
    prog_d  = 1'b0;
    susp_d  = 1'b0;
    res_d   = 1'b0;
    win_clr = 1'b0;
    win_add = 1'b0;
    unique case (mode_q)
      MODE_READ: begin
        unique case (cmd)
          CMD_AUTOSEL:   begin mode_d = MODE_AUTOSEL; ret_d = MODE_READ; end
          CMD_PROGRAM:   begin mode_d = MODE_PROGRAM; ret_d = MODE_READ; prog_d = 1'b1; end
          CMD_BYP_ENTER: mode_d = MODE_BYPASS;
          CMD_ERASE:     begin mode_d = MODE_ERASE_WIN; win_add = 1'b1; end
          default:       ;
        endcase
      end
      MODE_AUTOSEL: if (cmd == CMD_RESET) mode_d = ret_q;
      MODE_BYPASS: begin
        if (cmd == CMD_PROGRAM) begin
          mode_d = MODE_PROGRAM; ret_d = MODE_BYPASS; prog_d = 1'b1;
        end else if (cmd == CMD_BYP_EXIT) begin
          mode_d = MODE_READ;
        end
      end
      MODE_PROGRAM: if (op_done_i) mode_d = ret_q;
      MODE_ERASE_WIN: begin
        if (wr_en_i && wr_data_i == D_SECT) win_add = 1'b1;
        else if (win_exp)                   mode_d = MODE_ERASING;
      end
      MODE_ERASING: begin
        if (op_done_i) begin
          mode_d = MODE_READ; win_clr = 1'b1;
        end else if (wr_en_i && wr_data_i == D_SUSPEND) begin
          mode_d = MODE_SUSPENDED; susp_d = 1'b1;
        end
      end
      MODE_SUSPENDED: begin
        if (cmd == CMD_AUTOSEL) begin
          mode_d = MODE_AUTOSEL; ret_d = MODE_SUSPENDED;
        end else if (cmd == CMD_PROGRAM) begin
          if (!mask[wr_sect]) begin
            mode_d = MODE_PROGRAM; ret_d = MODE_SUSPENDED; prog_d = 1'b1;
          end
        end else if (seq_idle && wr_en_i && wr_data_i == D_SECT) begin
          mode_d = MODE_ERASING; res_d = 1'b1;
        end
      end
      default: mode_d = MODE_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_READ;
      ret_q       <= MODE_READ;
      prog_q      <= 1'b0;
      erase_q     <= 1'b0;
      susp_q      <= 1'b0;
      res_q       <= 1'b0;
      prog_addr_q <= '0;
      prog_data_q <= '0;
    end else begin
      mode_q  <= mode_d;
      ret_q   <= ret_d;
      prog_q  <= prog_d;
      erase_q <= win_exp && !win_add;
      susp_q  <= susp_d;
      res_q   <= res_d;
      if (prog_d) begin
        prog_addr_q <= wr_addr_i;
        prog_data_q <= wr_data_i;
      end
    end
  end

  assign mode_o        = mode_q;
  assign prog_start_o  = prog_q;
  assign prog_addr_o   = prog_addr_q;
  assign prog_data_o   = prog_data_q;
  assign erase_start_o = erase_q;
  assign erase_mask_o  = mask;
  assign suspend_o     = susp_q;
  assign resume_o      = res_q;
  assign rd_data_o     = (mode_q == MODE_AUTOSEL) ? rom_data : 16'h0000;

  a_r6_prog_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> (mode_o == MODE_PROGRAM));

  a_r10_start_from_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> (mode_o == MODE_ERASING && $past(mode_o) == MODE_ERASE_WIN));

  a_r10_mask_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_ERASING && $past(mode_o) == MODE_ERASING) |-> $stable(erase_mask_o));

  a_r11_suspend_from_erasing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> (mode_o == MODE_SUSPENDED && $past(mode_o) == MODE_ERASING));

  a_r12_resume_from_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (mode_o == MODE_ERASING && $past(mode_o) == MODE_SUSPENDED));

  a_r13_prog_outside_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_o && $past(mode_o) == MODE_SUSPENDED) |->
      !erase_mask_o[prog_addr_o[ADDR_W-1 -: SECT_W]]);

  a_r7_bypass_exit_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == MODE_BYPASS && mode_o == MODE_READ) |->
      $past(wr_en_i && wr_data_i == D_BYP_EXIT));
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int T = 16;
  localparam logic [15:0] MFR = 16'h00C5, D1 = 16'h2210, D2 = 16'h2211, D3 = 16'h2212;
  localparam logic [2:0] M_READ = 3'd0, M_ASEL = 3'd1, M_BYP = 3'd2, M_PROG = 3'd3,
                         M_WIN = 3'd4, M_ERS = 3'd5, M_SUSP = 3'd6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, op_done = 1'b0, fl = 1'b0, cl = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0, prot = '0;
  logic [15:0] rd_data, prog_addr;
  logic [7:0]  prog_data, mask;
  logic [2:0]  mode;
  logic        prog_start, erase_start, susp, res;
  logic        cap_prog, cap_susp, cap_res;
  int          n_chk = 0, n_err = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .sect_prot_i(prot), .fact_lock_i(fl),
    .cust_lock_i(cl), .op_done_i(op_done), .mode_o(mode), .prog_start_o(prog_start),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data), .erase_start_o(erase_start),
    .erase_mask_o(mask), .suspend_o(susp), .resume_o(res));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_id(input logic [15:0] a, input logic [7:0] p,
                                         input logic f, input logic c);
    logic [12:0] off = a[12:0];
    case (off)
      13'h00: return MFR;
      13'h01: return D1;
      13'h0E: return D2;
      13'h0F: return D3;
      13'h02: return {15'd0, p[a[15:13]]};
      13'h03: return f ? 16'h0081 : (c ? 16'h0041 : 16'h0001);
      default: return 16'h0000;
    endcase
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    cap_prog = prog_start; cap_susp = susp; cap_res = res;
  endtask

  task automatic unlock();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
  endtask

  task automatic cmd3(input logic [7:0] d);
    unlock(); wr(16'h0555, d);
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic id_reads(input int n);
    for (int i = 0; i < n; i++) begin
      logic [12:0] off;
      case ($urandom % 7)
        0: off = 13'h00; 1: off = 13'h01; 2: off = 13'h0E; 3: off = 13'h0F;
        4: off = 13'h02; 5: off = 13'h03; default: off = 13'($urandom);
      endcase
      prot = 8'($urandom); fl = 1'($urandom); cl = 1'($urandom);
      rd_addr = {3'($urandom), off};
      #1;
      if (off == 13'h03)      chk("R3 secured code", rd_data, exp_id(rd_addr, prot, fl, cl));
      else if (off == 13'h02) chk("R4 protect flag", rd_data, exp_id(rd_addr, prot, fl, cl));
      else                    chk("R2 id word", rd_data, exp_id(rd_addr, prot, fl, cl));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [2:0]  s1, s2, s3, sf;
    logic [15:0] a;
    logic [7:0]  d;
    void'($urandom(32'd20240917));
    idle(4);
    chk("R1 mode", mode, M_READ);
    chk("R1 strobes", {prog_start, erase_start, susp, res}, 4'b0);
    chk("R1 mask", mask, 8'h00);
    chk("R1 rd_data", rd_data, 16'h0);
    rst_n = 1'b1;
    idle(2);

    // ID readout
    cmd3(8'h90);
    chk("R2 enter id mode", mode, M_ASEL);
    id_reads(40);
    rd_addr = 16'h0000; prot = 8'h00; fl = 1'b1; cl = 1'b1; rd_addr = 16'h0003; #1;
    chk("R3 factory wins", rd_data, 16'h0081);
    wr(16'h1234, 8'hF0);
    chk("R5 reset to read", mode, M_READ);
    rd_addr = 16'h0000; #1;
    chk("R4 zero outside id", rd_data, 16'h0000);
    wr(16'h0000, 8'hF0);
    chk("R5 reset in read", mode, M_READ);

    // program from read, random patterns
    for (int i = 0; i < 12; i++) begin
      a = 16'($urandom); d = 8'($urandom);
      cmd3(8'hA0);
      wr(a, d);
      chk("R6 start", cap_prog, 1'b1);
      chk("R6 addr", prog_addr, a);
      chk("R6 data", prog_data, d);
      chk("R6 mode", mode, M_PROG);
      wr(16'h0555, 8'hAA);
      chk("R6 busy ignores", mode, M_PROG);
      done_pulse();
      chk("R6 done", mode, M_READ);
    end

    // lone A0 outside bypass
    wr(16'h0555, 8'hA0); wr(16'h0100, 8'h5A);
    chk("R8 no start", cap_prog, 1'b0);
    chk("R8 mode", mode, M_READ);

    // aborted sequences
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h12); wr(16'h0555, 8'h90);
    chk("R14 bad data aborts", mode, M_READ);
    wr(16'h0555, 8'hAA); wr(16'h0155, 8'h55); wr(16'h0555, 8'h90);
    chk("R14 bad addr aborts", mode, M_READ);
    unlock(); wr(16'h0123, 8'h90);
    chk("R14 bad third addr", mode, M_READ);

    // bypass
    cmd3(8'h20);
    chk("R7 enter bypass", mode, M_BYP);
    wr(16'h0000, 8'hF0);
    chk("R7 F0 ignored", mode, M_BYP);
    a = 16'($urandom); d = 8'($urandom);
    wr(16'h0777, 8'hA0); wr(a, d);
    chk("R7 bypass program", cap_prog, 1'b1);
    chk("R7 bypass addr", prog_addr, a);
    done_pulse();
    chk("R7 back to bypass", mode, M_BYP);
    wr(16'h0000, 8'h90); wr(16'h0000, 8'h11);
    chk("R7 wrong exit", mode, M_BYP);
    wr(16'h0000, 8'h90); wr(16'h0000, 8'h00);
    chk("R7 exit", mode, M_READ);

    // suspend outside erase
    wr(16'h0000, 8'hB0);
    chk("R11 B0 in read", {cap_susp, mode}, {1'b0, M_READ});

    // erase with append
    s1 = 3'($urandom);
    s2 = s1 + 3'(1 + $urandom % 7);
    s3 = s1 + 3'(1 + $urandom % 7);
    cmd3(8'h80); unlock();
    wr({s1, 13'($urandom)}, 8'h30);
    chk("R9 window", mode, M_WIN);
    chk("R9 mask", mask, 8'(1) << s1);
    idle(3);
    wr({s2, 13'($urandom)}, 8'h30);
    chk("R10 append", mask, (8'(1) << s1) | (8'(1) << s2));
    idle(T - 1);
    chk("R10 still open", {erase_start, mode}, {1'b0, M_WIN});
    idle(1);
    chk("R10 erase start", {erase_start, mode}, {1'b1, M_ERS});
    wr({s3, 13'h0}, 8'h30);
    chk("R10 no late add", mask, (8'(1) << s1) | (8'(1) << s2));
    chk("R10 mode", mode, M_ERS);

    // suspend and work inside it
    wr(16'h0000, 8'hB0);
    chk("R11 suspend", {cap_susp, mode}, {1'b1, M_SUSP});
    cmd3(8'hA0); wr({s1, 13'h0040}, 8'h77);
    chk("R13 masked program", {cap_prog, mode}, {1'b0, M_SUSP});
    sf = s1;
    for (int k = 1; k < 8; k++) begin
      if (sf == s1 && (s1 + 3'(k)) != s2) sf = s1 + 3'(k);
    end
    cmd3(8'hA0); wr({sf, 13'h0040}, 8'h3C);
    chk("R13 free program", {cap_prog, mode}, {1'b1, M_PROG});
    chk("R13 free data", prog_data, 8'h3C);
    done_pulse();
    chk("R13 back to suspend", mode, M_SUSP);
    cmd3(8'h90);
    chk("R13 id in suspend", mode, M_ASEL);
    rd_addr = 16'h0001; #1;
    chk("R2 dev id", rd_data, D1);
    wr(16'h0000, 8'hF0);
    chk("R13 F0 to suspend", mode, M_SUSP);
    wr(16'h0000, 8'h30);
    chk("R12 resume", {cap_res, mode}, {1'b1, M_ERS});
    done_pulse();
    chk("R12 done mode", mode, M_READ);
    chk("R12 mask cleared", mask, 8'h00);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule